// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles a conditional branch on operand equality while the branch instruction sits in the decode stage. It holds the fetch address and the fetch/decode pipeline register. It compares the two register operands with a dedicated comparator rather than the execute-stage ALU. It forms the branch destination from the incrementer value held with the instruction and the instruction's low 16 offset bits.

Fetch always proceeds sequentially, so the machine guesses that no branch is taken. When a branch resolves as taken, the fetch address is redirected to the destination. In the same cycle, the one instruction fetched behind the branch is squashed by loading the fetch/decode register with zeros, an encoding that decodes as a no-op. A stall from hazard logic freezes fetch and the decode register, but it cannot hold back a redirect that has already been decided.

Top module: `branch_resolver`

## Requirements
- R1: While reset is active, `fetch_pc` is RESET_PC (default 0), `ifid_instr` and `ifid_pc4` are zero, and `redirect` and `if_flush` are low.
- R2: `redirect` and `if_flush` are high in the same cycle exactly when `branch_en` is high and `rs_val` equals `rt_val`, with no clock edge in between.
- R3: `branch_target` always equals `ifid_pc4` plus the sign-extended `ifid_instr[15:0]` shifted left by two bits. For example, pc4 44 with offset 7 gives 72, and a negative offset lowers the result.
- R4: After a clock edge with `redirect` high, `fetch_pc` equals the `branch_target` shown before that edge.
- R5: After a clock edge with `if_flush` high, `ifid_instr` and `ifid_pc4` are all zero.
- R6: After an edge with neither redirect nor stall, `fetch_pc` has advanced by 4. At that edge, `ifid_instr` took `fetch_instr` and `ifid_pc4` took the old `fetch_pc` plus 4.
- R7: After an edge with `stall` high and no redirect, `fetch_pc`, `ifid_instr` and `ifid_pc4` are unchanged.
- R8: When `stall` and a taken branch coincide, the redirect and the flush still happen.
- R9: With `branch_en` low, equal operands cause neither redirect nor flush, and fetch stays sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| stall | input | 1 | Hold fetch address and decode register |
| fetch_instr | input | 32 | Instruction word read at `fetch_pc` |
| branch_en | input | 1 | Decoded instruction is branch-if-equal |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| fetch_pc | output | 32 | Current fetch address |
| ifid_instr | output | 32 | Instruction held in the fetch/decode register |
| ifid_pc4 | output | 32 | Incremented address held with that instruction |
| branch_target | output | 32 | Computed branch destination |
| redirect | output | 1 | Next fetch address comes from `branch_target` |
| if_flush | output | 1 | Decode register is squashed at the next edge |

## Verification
The decision outputs `redirect`, `if_flush` and `branch_target` are combinational, so they are due in the same cycle the inputs are applied. The bench compares them shortly after the falling edge on which it drove those inputs. The fetch address and the decode register are due one rising edge later. Each scoreboard item therefore carries both sets of expectations: the monitor checks the immediate values when it pops the item, and it checks the registered values at the following falling edge, after exactly one rising edge.

// File: rtl/branch_resolver_pkg.sv
package branch_resolver_pkg;
  // Source of the next fetch address
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_HOLD   = 2'd1,
    NPC_TARGET = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/bru_reset_sync.sv
module bru_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bru_eq_cmp.sv
module bru_eq_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              equal
);
  logic [DATA_W-1:0] bit_same;

  // Per-bit match, then a reduction
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign bit_same[i] = ~(op_a[i] ^ op_b[i]);
  end

  assign equal = &bit_same;
endmodule

// File: rtl/bru_target_gen.sv
module bru_target_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] base_pc4,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - OFF_W - SHIFT;

  logic [ADDR_W-1:0] disp;

  // Sign-extend and scale the word offset to a byte displacement
  assign disp   = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
  assign target = base_pc4 + disp;
endmodule

// File: rtl/bru_fetch_regs.sv
module bru_fetch_regs
  import branch_resolver_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              INSTR_W  = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  npc_sel_e           npc_sel,
  input  logic [ADDR_W-1:0]  target,
  input  logic [INSTR_W-1:0] fetch_instr,
  output logic [ADDR_W-1:0]  pc_q,
  output logic [INSTR_W-1:0] ifid_instr_q,
  output logic [ADDR_W-1:0]  ifid_pc4_q
);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(4);

  logic [ADDR_W-1:0]  pc_plus4;
  logic [ADDR_W-1:0]  pc_d;
  logic [INSTR_W-1:0] ifid_instr_d;
  logic [ADDR_W-1:0]  ifid_pc4_d;
  logic               load_en;

  assign pc_plus4 = pc_q + PC_STEP;

  always_comb begin
    load_en      = 1'b1;
    pc_d         = pc_plus4;
    ifid_instr_d = fetch_instr;
    ifid_pc4_d   = pc_plus4;
    unique case (npc_sel)
      NPC_TARGET: begin
        pc_d         = target;
        ifid_instr_d = '0;
        ifid_pc4_d   = '0;
      end
      NPC_HOLD: load_en = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q         <= RESET_PC;
      ifid_instr_q <= '0;
      ifid_pc4_q   <= '0;
    end else if (load_en) begin
      pc_q         <= pc_d;
      ifid_instr_q <= ifid_instr_d;
      ifid_pc4_q   <= ifid_pc4_d;
    end
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import branch_resolver_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter int                INSTR_W  = 32,
  parameter int                OFF_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall,
  input  logic [INSTR_W-1:0] fetch_instr,
  input  logic               branch_en,
  input  logic [DATA_W-1:0]  rs_val,
  input  logic [DATA_W-1:0]  rt_val,
  output logic [ADDR_W-1:0]  fetch_pc,
  output logic [INSTR_W-1:0] ifid_instr,
  output logic [ADDR_W-1:0]  ifid_pc4,
  output logic [ADDR_W-1:0]  branch_target,
  output logic               redirect,
  output logic               if_flush
);
  localparam int SHIFT = 2;

  logic     core_rst_n;
  logic     ops_equal;
  logic     taken;
  npc_sel_e npc_sel;

  bru_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(core_rst_n)
  );

  bru_eq_cmp #(.DATA_W(DATA_W)) u_cmp (
    .op_a(rs_val), .op_b(rt_val), .equal(ops_equal)
  );

  bru_target_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_tgt (
    .base_pc4(ifid_pc4), .offset(ifid_instr[OFF_W-1:0]), .target(branch_target)
  );

  // A resolved taken branch outranks a stall request
  assign taken = branch_en & ops_equal;

  always_comb begin
    if (taken)      npc_sel = NPC_TARGET;
    else if (stall) npc_sel = NPC_HOLD;
    else            npc_sel = NPC_SEQ;
  end

  bru_fetch_regs #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .RESET_PC(RESET_PC)) u_regs (
    .clk(clk), .rst_n(core_rst_n), .npc_sel(npc_sel), .target(branch_target),
    .fetch_instr(fetch_instr), .pc_q(fetch_pc), .ifid_instr_q(ifid_instr),
    .ifid_pc4_q(ifid_pc4)
  );

  assign redirect = (npc_sel == NPC_TARGET);
  assign if_flush = taken;
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stall,
  input logic               branch_en,
  input logic               redirect,
  input logic               if_flush,
  input logic [ADDR_W-1:0]  fetch_pc,
  input logic [ADDR_W-1:0]  branch_target,
  input logic [INSTR_W-1:0] ifid_instr,
  input logic [ADDR_W-1:0]  ifid_pc4
);
  // R2
  flush_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush == redirect);

  // R9
  no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !branch_en |-> (!if_flush && !redirect));

  // R4
  redirect_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> fetch_pc == $past(branch_target));

  // R5
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |=> (ifid_instr == '0 && ifid_pc4 == '0));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect) |=> ($stable(fetch_pc) && $stable(ifid_instr) && $stable(ifid_pc4)));

  // R6
  seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redirect) |=> fetch_pc == $past(fetch_pc) + ADDR_W'(4));
endmodule

bind branch_resolver branch_resolver_chk #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_chk (
  .clk(clk), .rst_n(core_rst_n), .stall(stall), .branch_en(branch_en),
  .redirect(redirect), .if_flush(if_flush), .fetch_pc(fetch_pc),
  .branch_target(branch_target), .ifid_instr(ifid_instr), .ifid_pc4(ifid_pc4)
);

// File: tb/branch_resolver_bench.sv
`timescale 1ns/1ps
module branch_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall;
  logic [31:0] fetch_instr;
  logic        branch_en;
  logic [31:0] rs_val, rt_val;
  logic [31:0] fetch_pc, ifid_instr, ifid_pc4, branch_target;
  logic        redirect, if_flush;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  branch_resolver u_branch_resolver (
    .clk(clk), .rst_n(rst_n), .stall(stall), .fetch_instr(fetch_instr),
    .branch_en(branch_en), .rs_val(rs_val), .rt_val(rt_val),
    .fetch_pc(fetch_pc), .ifid_instr(ifid_instr), .ifid_pc4(ifid_pc4),
    .branch_target(branch_target), .redirect(redirect), .if_flush(if_flush)
  );

  typedef struct {
    string       tag;
    logic        take;
    logic [31:0] tgt;
    logic [31:0] pc_nx;
    logic [31:0] ins_nx;
    logic [31:0] pc4_nx;
  } exp_t;

  exp_t exp_q[$];

  // Bench reference state
  logic [31:0] m_pc, m_ins, m_pc4;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic st, logic [31:0] fi, logic br,
                      logic [31:0] a, logic [31:0] b);
    exp_t e;
    logic [31:0] tgt;
    @(negedge clk);
    stall = st; fetch_instr = fi; branch_en = br; rs_val = a; rt_val = b;
    tgt = m_pc4 + {{14{m_ins[15]}}, m_ins[15:0], 2'b00};
    e.tag  = tag;
    e.take = br && (a == b);
    e.tgt  = tgt;
    if (e.take) begin
      m_pc = tgt; m_ins = '0; m_pc4 = '0;
    end else if (!st) begin
      m_ins = fi; m_pc4 = m_pc + 32'd4; m_pc = m_pc + 32'd4;
    end
    e.pc_nx = m_pc; e.ins_nx = m_ins; e.pc4_nx = m_pc4;
    exp_q.push_back(e);
  endtask

  // Monitor: registered results of the previous item, then immediate results of the new one
  initial begin
    exp_t pend;
    bit   have = 0;
    forever begin
      @(negedge clk);
      #1;
      if (have) begin
        check(pend.tag, fetch_pc, pend.pc_nx, "fetch_pc after edge");
        check(pend.tag, ifid_instr, pend.ins_nx, "ifid_instr after edge");
        check(pend.tag, ifid_pc4, pend.pc4_nx, "ifid_pc4 after edge");
      end
      have = 0;
      if (exp_q.size() > 0) begin
        pend = exp_q.pop_front();
        check(pend.tag, {31'd0, redirect}, {31'd0, pend.take}, "redirect");
        check(pend.tag, {31'd0, if_flush}, {31'd0, pend.take}, "if_flush");
        check(pend.tag, branch_target, pend.tgt, "branch_target");
        have = 1;
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0; stall = 1'b1; fetch_instr = '0; branch_en = 1'b0;
    rs_val = 32'd1; rt_val = 32'd2;
    m_pc = '0; m_ins = '0; m_pc4 = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1", fetch_pc, 32'd0, "fetch_pc in reset");
    check("R1", ifid_instr, 32'd0, "ifid_instr in reset");
    check("R1", ifid_pc4, 32'd0, "ifid_pc4 in reset");
    check("R1", {30'd0, redirect, if_flush}, 32'd0, "decision in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 sequential fetch, R9 equal operands without branch_en
    for (int k = 0; k < 10; k++)
      step("R6_R9", 1'b0, 32'hA000_0000 + k, 1'b0, 32'd9, (k % 2 == 0) ? 32'd9 : 32'd3);
    step("R6", 1'b0, 32'h1000_0007, 1'b0, 32'd1, 32'd2); // fetched at 40, offset 7
    // R3 R4 R5: pc4 44 + 7*4 -> 72, flush decode register
    step("R4_R5", 1'b0, 32'hBEEF_0001, 1'b1, 32'd5, 32'd5);
    step("R6", 1'b0, 32'h0000_FFFE, 1'b0, 32'd0, 32'd1); // fetched at 72, offset -2
    // R2: branch with unequal operands is not taken; R3 negative offset 76-8
    step("R2_R3", 1'b0, 32'h1234_FFFC, 1'b1, 32'd7, 32'd8);
    // R7 stall holds everything
    step("R7", 1'b1, 32'hDEAD_0000, 1'b0, 32'd0, 32'd0);
    step("R7", 1'b1, 32'hDEAD_0001, 1'b1, 32'd1, 32'd2);
    // R8 stall with taken branch: redirect to 80-16=64
    step("R8", 1'b1, 32'hDEAD_0002, 1'b1, 32'h55, 32'h55);
    // Mixed pattern
    lf = 32'hACE1_0013;
    for (int k = 0; k < 24; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step("R2_R6", lf[3], lf, lf[5], {30'd0, lf[7:6]}, {30'd0, lf[9:8]});
    end
    step("R6", 1'b0, 32'd0, 1'b0, 32'd0, 32'd1);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule